// File: doc/BRIEF.md
# Half-Resolution RGB555 Frame Capture Writer

This block sits between a streaming video capture path and a 16-bit synchronous SRAM used as a frame buffer. Each incoming pixel arrives as three 8-bit colour channels qualified by a valid strobe. Two markers ride on valid pixels: one flags the first pixel of every line, and another flags the first pixel of a frame. The block halves the picture in both directions. It drops every odd line and every odd pixel of the even lines. Each surviving pixel is packed into a 15-bit colour word with a zero top bit and written to consecutive SRAM addresses in raster order.

Software or a bus arbiter controls capture through two inputs. `enable` arms the block. `grant` tells it that the memory bus currently belongs to the video-write side. Capture never starts in the middle of a picture: it waits for a frame-start pixel that is seen while both inputs are high. When the last word of the reduced frame has been written, `frame_done` rises and stays high, and no further writes happen, until `enable` is dropped. Raising `enable` again arms the block for a fresh frame starting at address 0. With the default 640x480 input, the stored frame is 320x240, which is 76800 words.

The controller is a four-state machine:
- IDLE: disabled. It moves to ARMED once `enable` is high.
- ARMED: waits for a frame-start pixel with `grant` high. That pixel is written, and the state moves to CAPTURE, or straight to DONE if the frame is a single word.
- CAPTURE: writes kept pixels. It moves to DONE after the final address is written, back to ARMED if `grant` falls (abort), and to IDLE if `enable` falls.
- DONE: holds the result. It returns to IDLE when `enable` falls.

Top module: `vdec_frame_capture`

## Requirements
- R1: Counting the frame-start line as line 0, only even-numbered lines produce SRAM writes.
- R2: Within a kept line, counting the line-start pixel as pixel 0, only even-numbered pixels produce writes.
- R3: A written word places the upper five bits of red in bits 14:10, of green in bits 9:5 and of blue in bits 4:0. Bit 15 is 0.
- R4: The write strobe, address and data are registered, so they appear in the cycle after the kept pixel. Addresses start at 0 for each captured frame and rise by one per write.
- R5: No write occurs unless capture began at a frame-start pixel seen while `enable` and `grant` were both high. Pixels of a frame already in progress when the block is armed are never written.
- R6: One cycle after the write to the final address (word count minus one), `frame_done` is high. From then on there are no writes, and `frame_done` stays high while `enable` stays high, even across further frames.
- R7: After `enable` is seen low, `frame_done` is low in the following cycle. Re-enabling captures a new whole frame from address 0.
- R8: Writes happen only in the cycle after `grant` was high. If `grant` falls during capture, the frame is abandoned without `frame_done`, and the next frame-start pixel with `grant` high restarts at address 0.
- R9: While reset is held, `sram_we` and `frame_done` are 0 and `sram_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Arms capture; low clears frame_done |
| grant | input | 1 | Memory bus granted to the video-write side |
| pix_valid | input | 1 | Pixel inputs carry a pixel this cycle |
| line_start | input | 1 | First pixel of a line (with pix_valid) |
| frame_start | input | 1 | First pixel of a frame (with pix_valid and line_start) |
| pix_r | input | CH_W | Red channel |
| pix_g | input | CH_W | Green channel |
| pix_b | input | CH_W | Blue channel |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_data | output | 16 | Packed RGB555 word |
| sram_we | output | 1 | SRAM write strobe, one word per cycle |
| frame_done | output | 1 | Reduced frame completely stored |

## Verification
The hardest situation to reach from the ports is a capture that was aborted partway through a frame, followed by a clean restart. The stimulus drops `grant` on a kept line in the middle of a frame and keeps streaming the rest of that frame. It then checks that no writes follow and that `frame_done` stays low. Finally it restores `grant` and streams a full frame, checking every write against a reference address counter that restarts at 0. Arming in the middle of a frame is reached the same way, by raising `enable` and streaming lines that carry no frame-start marker.

// File: rtl/vdec_pkg.sv
package vdec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } cap_state_t;

    localparam int FIELD_W = 5;
    localparam int WORD_W  = 16;
endpackage

// File: rtl/vdec_rgb555_pack.sv
module vdec_rgb555_pack
    import vdec_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic [CH_W-1:0]   red,
    input  logic [CH_W-1:0]   green,
    input  logic [CH_W-1:0]   blue,
    output logic [WORD_W-1:0] word
);
    // Keep the top FIELD_W bits of each channel; the spare top bit is zero.
    always_comb begin
        word = {1'b0,
                red  [CH_W-1 -: FIELD_W],
                green[CH_W-1 -: FIELD_W],
                blue [CH_W-1 -: FIELD_W]};
    end
endmodule

// File: rtl/vdec_keep_sel.sv
module vdec_keep_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_valid,
    input  logic line_start,
    input  logic frame_start,
    output logic keep
);
    // Only parities are needed: odd line / odd pixel of the pixel just seen.
    logic line_odd_q, pix_odd_q;
    logic cur_line_odd, cur_pix_odd;

    always_comb begin
        if (frame_start)
            cur_line_odd = 1'b0;
        else if (line_start)
            cur_line_odd = ~line_odd_q;
        else
            cur_line_odd = line_odd_q;
        cur_pix_odd = (line_start || frame_start) ? 1'b0 : pix_odd_q;
        keep = pix_valid && !cur_line_odd && !cur_pix_odd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_odd_q <= 1'b0;
            pix_odd_q  <= 1'b0;
        end else if (pix_valid) begin
            line_odd_q <= cur_line_odd;
            pix_odd_q  <= ~cur_pix_odd;
        end
    end

    // R1: a marked line start flips the line parity exactly once
    assert_line_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && line_start && !frame_start) |=> (line_odd_q != $past(line_odd_q)));
endmodule

// File: rtl/vdec_addr_gen.sv
module vdec_addr_gen #(
    parameter int WORDS  = 76800,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (clr)
            addr_q <= '0;
        else if (step)
            addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;
    assign last = (addr_q == LAST_ADDR);

    // R4: the word pointer never leaves the reduced frame
    assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= LAST_ADDR);
endmodule

// File: rtl/vdec_frame_capture.sv
module vdec_frame_capture
    import vdec_pkg::*;
#(
    parameter int IN_W   = 640,
    parameter int IN_H   = 480,
    parameter int CH_W   = 8,
    parameter int ADDR_W = $clog2((IN_W / 2) * (IN_H / 2))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              grant,
    input  logic              pix_valid,
    input  logic              line_start,
    input  logic              frame_start,
    input  logic [CH_W-1:0]   pix_r,
    input  logic [CH_W-1:0]   pix_g,
    input  logic [CH_W-1:0]   pix_b,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [WORD_W-1:0] sram_data,
    output logic              sram_we,
    output logic              frame_done
);
    localparam int OUT_W = IN_W / 2;
    localparam int OUT_H = IN_H / 2;
    localparam int WORDS = OUT_W * OUT_H;

    cap_state_t        st, st_n;
    logic              keep, wr_fire, start_hit, addr_clr;
    logic              at_last;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] packed_word;

    vdec_keep_sel u_keep (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid   (pix_valid),
        .line_start  (line_start),
        .frame_start (frame_start),
        .keep        (keep)
    );

    vdec_rgb555_pack #(.CH_W(CH_W)) u_pack (
        .red   (pix_r),
        .green (pix_g),
        .blue  (pix_b),
        .word  (packed_word)
    );

    vdec_addr_gen #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (addr_clr),
        .step  (wr_fire),
        .addr  (cur_addr),
        .last  (at_last)
    );

    always_comb begin
        start_hit = pix_valid && frame_start && enable && grant;
        wr_fire   = keep && enable && grant &&
                    ((st == ST_CAPTURE) || (st == ST_ARMED && frame_start));
        st_n = st;
        unique case (st)
            ST_IDLE:    if (enable) st_n = ST_ARMED;
            ST_ARMED: begin
                if (!enable)        st_n = ST_IDLE;
                else if (start_hit) st_n = at_last ? ST_DONE : ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (!enable)                st_n = ST_IDLE;
                else if (!grant)            st_n = ST_ARMED;
                else if (wr_fire && at_last) st_n = ST_DONE;
            end
            ST_DONE:    if (!enable) st_n = ST_IDLE;
        endcase
        addr_clr = (st_n != ST_CAPTURE);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_we    <= 1'b0;
            sram_addr  <= '0;
            sram_data  <= '0;
            frame_done <= 1'b0;
        end else begin
            sram_we    <= wr_fire;
            frame_done <= (st == ST_DONE) && enable;
            if (wr_fire) begin
                sram_addr <= cur_addr;
                sram_data <= packed_word;
            end
        end
    end

    // R8: a write strobe always follows a granted cycle
    assert_we_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> $past(grant));

    // R3: the red field written equals the red input of the previous cycle
    assert_red_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (sram_data[14:10] == $past(pix_r[CH_W-1 -: FIELD_W]) && !sram_data[15]));

    // R6: no writes once the frame is reported complete
    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !sram_we);

    // R6: completion is held while enable stays high
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && enable && $past(enable)) |=> frame_done);

    // R7: a low enable clears completion in the next cycle
    assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !frame_done);
endmodule

// File: tb/sim_vdec_frame_capture.sv
module sim_vdec_frame_capture;
    localparam int IN_W  = 8;
    localparam int IN_H  = 6;
    localparam int WORDS = (IN_W / 2) * (IN_H / 2);
    localparam int AW    = $clog2(WORDS);

    // {r, g, b, expected packed word}
    localparam logic [39:0] VEC [8] = '{
        {8'hFF, 8'hFF, 8'hFF, 16'h7FFF},
        {8'h00, 8'h00, 8'h00, 16'h0000},
        {8'hF8, 8'h00, 8'h00, 16'h7C00},
        {8'h00, 8'hF8, 8'h00, 16'h03E0},
        {8'h00, 8'h00, 8'hF8, 16'h001F},
        {8'h07, 8'h07, 8'h07, 16'h0000},
        {8'h08, 8'h10, 8'h18, 16'h0443},
        {8'h80, 8'h40, 8'h20, 16'h4104}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, grant = 1'b1;
    logic pix_valid = 1'b0, line_start = 1'b0, frame_start = 1'b0;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic [AW-1:0] sram_addr;
    logic [15:0] sram_data;
    logic sram_we, frame_done;

    int total = 0, bad = 0, writes = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vdec_frame_capture #(.IN_W(IN_W), .IN_H(IN_H), .CH_W(8), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .grant(grant),
        .pix_valid(pix_valid), .line_start(line_start), .frame_start(frame_start),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .sram_addr(sram_addr), .sram_data(sram_data), .sram_we(sram_we),
        .frame_done(frame_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Stream one frame from first_line; capture=1 means writes are expected.
    // Grant drops at the start of drop_line (-1: never).
    task automatic send_frame(input int first_line, input bit capture,
                              input int drop_line, input string tag);
        int exp_addr = 0;
        bit live = capture;
        writes = 0;
        for (int ln = first_line; ln < IN_H; ln++) begin
            if (ln == drop_line) begin
                grant = 1'b0;
                live = 1'b0;
            end
            for (int c = 0; c < IN_W; c++) begin
                int idx = ((ln / 2) * (IN_W / 2) + c / 2) % 8;
                bit kept = live && (ln % 2 == 0) && (c % 2 == 0);
                pix_valid   = 1'b1;
                line_start  = (c == 0);
                frame_start = (c == 0) && (ln == 0);
                pix_r = VEC[idx][39:32];
                pix_g = VEC[idx][31:24];
                pix_b = VEC[idx][23:16];
                tick();
                if (!live)          chk({tag, " we"}, sram_we, 0);
                else if (ln % 2)    chk("R1 odd line dropped", sram_we, 0);
                else if (c % 2)     chk("R2 odd pixel dropped", sram_we, 0);
                else                chk("R1 R2 kept pixel written", sram_we, 1);
                if (kept && sram_we) begin
                    writes++;
                    chk("R4 address", sram_addr, exp_addr);
                    chk("R3 packed word", sram_data, VEC[idx][15:0]);
                end
                if (kept) exp_addr++;
            end
            pix_valid = 1'b0;
            line_start = 1'b0;
            frame_start = 1'b0;
            tick();
            chk({tag, " blank"}, sram_we, 0);
        end
    endtask

    initial begin
        // R9: reset state
        repeat (3) tick();
        chk("R9 we in reset", sram_we, 0);
        chk("R9 done in reset", frame_done, 0);
        chk("R9 addr in reset", sram_addr, 0);
        rst_n = 1'b1;
        tick();

        // R5: disabled block ignores a whole frame
        send_frame(0, 1'b0, -1, "R5 disabled");
        chk("R5 no done while disabled", frame_done, 0);

        // R5: armed mid-frame, partial frame ignored
        enable = 1'b1;
        repeat (2) tick();
        send_frame(2, 1'b0, -1, "R5 partial frame");
        chk("R5 no done after partial", frame_done, 0);

        // Full frame with table-driven colours
        send_frame(0, 1'b1, -1, "R4 capture");
        chk("R6 all words written", writes, WORDS);
        chk("R6 done after frame", frame_done, 1);

        // R6: further frame while done
        send_frame(0, 1'b0, -1, "R6 after done");
        chk("R6 done held", frame_done, 1);

        // R7: clear and re-arm
        enable = 1'b0;
        tick();
        chk("R7 done cleared", frame_done, 0);
        enable = 1'b1;
        repeat (2) tick();
        send_frame(0, 1'b1, -1, "R7 recapture");
        chk("R7 recapture word count", writes, WORDS);
        chk("R7 done again", frame_done, 1);

        // R8: grant lost mid-frame, then clean restart
        enable = 1'b0;
        tick();
        enable = 1'b1;
        repeat (2) tick();
        send_frame(0, 1'b1, 2, "R8 grant lost");
        chk("R8 writes before abort", writes, IN_W / 2);
        chk("R8 no done after abort", frame_done, 0);
        grant = 1'b1;
        tick();
        send_frame(0, 1'b1, -1, "R8 restart");
        chk("R8 restart word count", writes, WORDS);
        chk("R8 done after restart", frame_done, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule